// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives asynchronous characters from the single I/O line of a smart card. After a two-flop synchronizer it finds the falling edge of a start bit and confirms the start bit half an elementary time unit (ETU) later. It then samples eight data bits, least significant bit first, and an even-parity bit, each at the middle of its ETU. The ETU length is a parameter, `ETU_CLKS`, with a default of 372 clocks.

A completed character goes to a data register, and a status register records the outcome. The status register holds a data-ready flag and three sticky error flags: overrun, parity and waiting time. The protocol mode decides what happens to a character that arrives with bad parity. In character mode (T=0) the character is dropped, and the receiver pulls the line low for one ETU to ask the card to send it again. In block mode (T=1) the character is delivered anyway.

A waiting-time timer restarts at each accepted start bit. It flags an error when the card stays silent for longer than the programmed number of ETUs. Two interrupt requests are gated by the enable bits. The host reaches everything through a small register port.

Register map. The address is `regAddr`, and the read data on `regRdData` is combinational.
- Address 0 is control (read/write): bit0 receive enable, bit1 T=1 mode, bit2 interrupt enable, bit3 error-only interrupts.
- Address 1 is status: bit0 data ready (read only), bit1 overrun, bit2 parity error, bit3 waiting-time error.
- Address 2 is received data (read only).
- Address 3 is the waiting-time limit in ETUs. A value of 0 turns the timer off.

Top module: `scRx`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent LSB first, then a parity bit that makes the count of ones in data plus parity even, each bit ETU_CLKS clocks long. A good frame is loaded into the data register (address 2) and sets data ready (status bit0).
- R2: If the line is high again when the start bit is checked half an ETU after the falling edge, the edge is dropped. No flag or data changes, and the timer is not restarted.
- R3: In T=0 mode (control bit1 = 0), a frame with bad parity sets status bit2. It does not load the data register and does not change data ready.
- R4: In T=0 mode, after a bad-parity frame the output `ioDriveLow` goes high for exactly ETU_CLKS clocks. It starts one ETU after the parity-bit sample point.
- R5: In T=1 mode (control bit1 = 1), a frame with bad parity sets status bit2 and is still loaded into the data register with data ready set. No line drive follows.
- R6: When a frame completes while data ready is already 1 and the data is not being read in that cycle, status bit1 (overrun) is set and the data register keeps its old value.
- R7: A read of address 2 clears data ready.
- R8: Status bits 1 to 3 stay set until the host writes 0 to the bit at address 1. Writing 1 has no effect, and a new error set in the same cycle takes priority over the clear.
- R9: `rxIrq` is 1 exactly when the interrupt enable (control bit2) is 1, error-only (control bit3) is 0, and data ready is 1.
- R10: `errIrq` is 1 exactly when the interrupt enable is 1 and at least one of status bits 1 to 3 is 1.
- R11: With a nonzero limit N at address 3, status bit3 is set N·ETU_CLKS clocks after the last accepted start bit, or after reception was enabled. It fires once and does not fire again before the next start bit.
- R12: With the receive enable (control bit0) at 0, activity on the line changes no flag or data, the waiting-time timer does not run, and clearing the enable drops a frame that is in progress.
- R13: After reset all four registers read 0, and `rxIrq`, `errIrq` and `ioDriveLow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioIn | input | 1 | Card I/O line level |
| ioDriveLow | output | 1 | Pull the card I/O line low (error signal) |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on address 2) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on regAddr |
| rxIrq | output | 1 | Receive-data-full interrupt request |
| errIrq | output | 1 | Receive-error interrupt request |

## Verification
Call E0 the first clock edge that captures the start-bit low. With that reference, the start bit is accepted and the waiting-time timer restarts at edge E0+2+ETU/2. Flags and data from the frame change at edge E0+3+ETU/2+9·ETU. In T=0 mode the error drive covers the edges from that commit edge plus ETU−1 up to the commit edge plus 2·ETU−2. The waiting-time error appears N·ETU edges after the restart.

Host writes and reads take effect at the edge that samples them. The interrupt outputs follow the register state with no added latency. The bench reference model applies each of these events at the edge computed above and compares the interrupt and drive outputs at every falling clock edge. Register reads are sampled while the read strobe is held, before the edge that acts on them.

// File: rtl/scRxPkg.sv
package scRxPkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_WAIT = 2'd3;

  localparam int CTL_EN    = 0;
  localparam int CTL_T1    = 1;
  localparam int CTL_IE    = 2;
  localparam int CTL_EONLY = 3;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_PAR  = 2;
  localparam int ST_WAIT = 3;

  // strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic startOk;   // start bit confirmed at mid-bit
    logic shiftIn;   // sample the line into the shift register
    logic commit;    // frame complete, update data and flags
    logic driveLow;  // error signal on the line
  } rxStrobeT;
endpackage

// File: rtl/scRxCtrl.sv
module scRxCtrl
  import scRxPkg::*;
#(
  parameter int ETU_CLKS = 372
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxEnable,
  input  logic     t1Mode,
  input  logic     lineS,
  input  logic     lineFall,
  input  logic     parityBad,
  output rxStrobeT strobe
);
  localparam int CNT_W = $clog2(ETU_CLKS);
  localparam int HALF  = ETU_CLKS / 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ETU_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_GAP  = CNT_W'(ETU_CLKS - 2);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_CHECK, S_GAP, S_DRIVE} phaseT;

  phaseT            phase;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      phase  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (phase)
        S_IDLE: begin
          if (lineFall) begin
            phase <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (cnt == CNT_HALF) begin
            cnt    <= '0;
            bitIdx <= '0;
            phase  <= lineS ? S_IDLE : S_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BITS: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (bitIdx == IDX_LAST) phase <= S_CHECK;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CHECK: begin
          cnt   <= '0;
          phase <= (!t1Mode && parityBad) ? S_GAP : S_IDLE;
        end
        S_GAP: begin
          if (cnt == CNT_GAP) begin
            cnt   <= '0;
            phase <= S_DRIVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRIVE: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            phase <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.startOk  = rxEnable && (phase == S_START) && (cnt == CNT_HALF) && !lineS;
    strobe.shiftIn  = rxEnable && (phase == S_BITS) && (cnt == CNT_LAST);
    strobe.commit   = rxEnable && (phase == S_CHECK);
    strobe.driveLow = (phase == S_DRIVE);
  end

  // R12: a cleared enable always returns the sequencer to idle
  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> phase == S_IDLE);

  // R2: a start bit seen high at mid-bit is dropped
  assert_glitch_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_START && cnt == CNT_HALF && lineS) |=> (phase == S_IDLE && !strobe.shiftIn));

  // R4: the error drive only ever follows the guard gap
  assert_drive_after_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.driveLow) |-> $past(phase) == S_GAP);
endmodule

// File: rtl/scRxPath.sv
module scRxPath
  import scRxPkg::*;
#(
  parameter int ETU_CLKS = 372
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  rxStrobeT          strobe,
  output logic              ioDriveLow,
  output logic [REG_W-1:0]  regRdData,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              lineS,
  output logic              lineFall,
  output logic              parityBad,
  output logic              rxEnable,
  output logic              t1Mode
);
  localparam int CNT_W = $clog2(ETU_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ETU_CLKS - 1);

  // line synchronizer and edge detect
  logic syncA, syncB, linePrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      syncA    <= ioIn;
      syncB    <= syncA;
      linePrev <= syncB;
    end
  end
  assign lineS    = syncB;
  assign lineFall = linePrev && !syncB;

  // shift register: data LSB first, parity in the top bit
  logic [DATA_W:0] shiftReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftIn) shiftReg <= {lineS, shiftReg[DATA_W:1]};
  end
  assign parityBad = ^shiftReg;

  // host access decode
  logic ctrlWr, statWr, waitWr, dataRd;
  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign statWr = regWrEn && (regAddr == ADDR_STAT);
  assign waitWr = regWrEn && (regAddr == ADDR_WAIT);
  assign dataRd = regRdEn && (regAddr == ADDR_DATA);

  logic intEn, errOnly;
  logic [REG_W-1:0] waitLimit;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable  <= 1'b0;
      t1Mode    <= 1'b0;
      intEn     <= 1'b0;
      errOnly   <= 1'b0;
      waitLimit <= '0;
    end else begin
      if (ctrlWr) begin
        rxEnable <= regWrData[CTL_EN];
        t1Mode   <= regWrData[CTL_T1];
        intEn    <= regWrData[CTL_IE];
        errOnly  <= regWrData[CTL_EONLY];
      end
      if (waitWr) waitLimit <= regWrData;
    end
  end

  // waiting-time timer
  logic [CNT_W-1:0] waitClk;
  logic [REG_W-1:0] waitEtu;
  logic             waitFired, waitFire, waitRun;
  assign waitRun  = rxEnable && !strobe.startOk && (waitLimit != '0) && !waitFired;
  assign waitFire = waitRun && (waitClk == CNT_LAST) && ((waitEtu + 1'b1) == waitLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitClk   <= '0;
      waitEtu   <= '0;
      waitFired <= 1'b0;
    end else if (!rxEnable || strobe.startOk) begin
      waitClk   <= '0;
      waitEtu   <= '0;
      waitFired <= 1'b0;
    end else if (waitRun) begin
      if (waitClk == CNT_LAST) begin
        waitClk <= '0;
        waitEtu <= waitEtu + 1'b1;
        if (waitFire) waitFired <= 1'b1;
      end else begin
        waitClk <= waitClk + 1'b1;
      end
    end
  end

  // data register and status flags
  logic [DATA_W-1:0] rxData;
  logic dataFull, overrun, parErr, waitErr;
  logic keepChar, blocked;
  assign keepChar = strobe.commit && (!parityBad || t1Mode);
  assign blocked  = dataFull && !dataRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      dataFull <= 1'b0;
      overrun  <= 1'b0;
      parErr   <= 1'b0;
      waitErr  <= 1'b0;
    end else begin
      if (keepChar && !blocked) begin
        rxData   <= shiftReg[DATA_W-1:0];
        dataFull <= 1'b1;
      end else if (dataRd) begin
        dataFull <= 1'b0;
      end

      if (keepChar && blocked) overrun <= 1'b1;
      else if (statWr && !regWrData[ST_OVR]) overrun <= 1'b0;

      if (strobe.commit && parityBad) parErr <= 1'b1;
      else if (statWr && !regWrData[ST_PAR]) parErr <= 1'b0;

      if (waitFire) waitErr <= 1'b1;
      else if (statWr && !regWrData[ST_WAIT]) waitErr <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[CTL_EN]    = rxEnable;
        regRdData[CTL_T1]    = t1Mode;
        regRdData[CTL_IE]    = intEn;
        regRdData[CTL_EONLY] = errOnly;
      end
      ADDR_STAT: begin
        regRdData[ST_FULL] = dataFull;
        regRdData[ST_OVR]  = overrun;
        regRdData[ST_PAR]  = parErr;
        regRdData[ST_WAIT] = waitErr;
      end
      ADDR_DATA: regRdData = REG_W'(rxData);
      default:   regRdData = waitLimit;
    endcase
  end

  assign rxIrq      = intEn && !errOnly && dataFull;
  assign errIrq     = intEn && (overrun || parErr || waitErr);
  assign ioDriveLow = strobe.driveLow;

  // R1: data ready only rises on a frame commit
  assert_full_from_commit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataFull) |-> $past(strobe.commit));

  // R3: a T=0 bad-parity frame leaves the data register alone
  assert_t0_bad_no_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && parityBad && !t1Mode) |=> $stable(rxData));

  // R6: overrun keeps the previous character
  assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keepChar && dataFull && !dataRd) |=> ($stable(rxData) && overrun));

  // R7: a data read frees the register when no frame lands
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strobe.commit) |=> !dataFull);

  // R8: error flags persist without a status write
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((overrun || parErr || waitErr) && !statWr) |=>
      ((overrun || !$past(overrun)) && (parErr || !$past(parErr)) && (waitErr || !$past(waitErr))));
endmodule

// File: rtl/scRx.sv
module scRx
  import scRxPkg::*;
#(
  parameter int ETU_CLKS = 372
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioIn,
  output logic       ioDriveLow,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       rxIrq,
  output logic       errIrq
);
  rxStrobeT strobe;
  logic lineS, lineFall, parityBad, rxEnable, t1Mode;

  scRxCtrl #(.ETU_CLKS(ETU_CLKS)) ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .t1Mode(t1Mode),
    .lineS(lineS), .lineFall(lineFall), .parityBad(parityBad), .strobe(strobe)
  );

  scRxPath #(.ETU_CLKS(ETU_CLKS)) path (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .strobe(strobe), .ioDriveLow(ioDriveLow),
    .regRdData(regRdData), .rxIrq(rxIrq), .errIrq(errIrq), .lineS(lineS),
    .lineFall(lineFall), .parityBad(parityBad), .rxEnable(rxEnable), .t1Mode(t1Mode)
  );
endmodule

// File: tb/scRx_test.sv
module scRx_test;
  localparam int ETU  = 16;
  localparam int HALF = ETU / 2;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cardLine = 1'b1;
  logic ioIn, ioDriveLow, regWrEn, regRdEn, rxIrq, errIrq;
  logic [1:0] regAddr;
  logic [7:0] regWrData, regRdData;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;
  assign ioIn = cardLine & ~ioDriveLow;

  scRx #(.ETU_CLKS(ETU)) uut (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .ioDriveLow(ioDriveLow),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int cyc = 0;
  logic mEn = 0, mT1 = 0, mIe = 0, mEo = 0;
  logic [7:0] mLimit = 0, mData = 0;
  logic mFull = 0, mOvr = 0, mPar = 0, mWait = 0, mFired = 0;
  int mLast = 0;
  int dFrom = -1, dTo = -2;
  int startQ[$];
  int cmtQ[$];
  logic [7:0] cmtData[$];
  bit cmtBad[$];

  always @(posedge clk) begin : model
    bit rd, sw, bad, store;
    logic [7:0] dat;
    cyc++;
    if (rstN) begin
      rd = regRdEn && regAddr == 2'd2;
      sw = regWrEn && regAddr == 2'd1;
      if (startQ.size() > 0 && startQ[0] == cyc) begin
        void'(startQ.pop_front());
        if (mEn) begin mLast = cyc; mFired = 0; end
      end else if (mEn && mLimit != 0 && !mFired && cyc == mLast + int'(mLimit) * ETU) begin
        mFired = 1;
        mWait = 1;
      end else if (sw && !regWrData[3]) mWait = 0;
      if (sw && !regWrData[1]) mOvr = 0;
      if (sw && !regWrData[2]) mPar = 0;
      if (rd) mFull = 0;
      if (cmtQ.size() > 0 && cmtQ[0] == cyc) begin
        void'(cmtQ.pop_front());
        dat = cmtData.pop_front();
        bad = cmtBad.pop_front();
        if (mEn) begin
          if (bad) mPar = 1;
          store = !bad || mT1;
          if (store) begin
            if (rd || !mFull) begin mData = dat; mFull = 1; end
            else mOvr = 1;
          end
          if (bad && !mT1) begin dFrom = cyc + ETU - 1; dTo = cyc + 2 * ETU - 2; end
        end
      end
      if (regWrEn && regAddr == 2'd0) begin
        if (!mEn && regWrData[0]) begin mLast = cyc; mFired = 0; end
        mEn = regWrData[0]; mT1 = regWrData[1]; mIe = regWrData[2]; mEo = regWrData[3];
      end
      if (regWrEn && regAddr == 2'd3) mLimit = regWrData;
    end
  end

  // per-clock comparison of the free-running outputs
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 rxIrq", {7'b0, rxIrq}, {7'b0, mIe & ~mEo & mFull});
      chk("R10 errIrq", {7'b0, errIrq}, {7'b0, mIe & (mOvr | mPar | mWait)});
      chk("R4 ioDriveLow", {7'b0, ioDriveLow}, {7'b0, (cyc >= dFrom && cyc <= dTo) ? 1'b1 : 1'b0});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a; regRdEn = (a == 2'd2);
    #1 chk(tag, regRdData, exp);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] d, input bit badPar);
    int e0;
    @(negedge clk);
    e0 = cyc + 1;
    if (mEn) begin
      startQ.push_back(e0 + 2 + HALF);
      cmtQ.push_back(e0 + 3 + HALF + 9 * ETU);
      cmtData.push_back(d);
      cmtBad.push_back(badPar);
    end
    cardLine = 1'b0;
    repeat (ETU) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      cardLine = d[i];
      repeat (ETU) @(negedge clk);
    end
    cardLine = (^d) ^ badPar;
    repeat (ETU) @(negedge clk);
    cardLine = 1'b1;
    repeat (GAP * ETU) @(negedge clk);
  endtask

  task automatic idleEtus(input int n);
    repeat (n * ETU) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    regCheck(2'd0, 8'h00, "R13 ctrl");
    regCheck(2'd1, 8'h00, "R13 status");
    regCheck(2'd2, 8'h00, "R13 data");
    regCheck(2'd3, 8'h00, "R13 wait");
    chk("R13 outputs", {5'b0, rxIrq, errIrq, ioDriveLow}, 8'h00);

    regWrite(2'd3, 8'd40);
    regWrite(2'd0, 8'h05);
    // R1 good frame
    sendChar(8'hA5, 0);
    regCheck(2'd1, 8'h01, "R1 status");
    regCheck(2'd2, 8'hA5, "R1 data");
    regCheck(2'd1, 8'h00, "R7 read clears ready");
    // R3/R4 T=0 parity error
    sendChar(8'h3C, 1);
    regCheck(2'd1, 8'h04, "R3 status");
    regCheck(2'd2, 8'hA5, "R3 data unchanged");
    chk("R10 errIrq on parity", {7'b0, errIrq}, 8'h01);
    // R8 write-one no effect, write-zero clears
    regWrite(2'd1, 8'h0E);
    regCheck(2'd1, 8'h04, "R8 write one ignored");
    regWrite(2'd1, 8'h00);
    regCheck(2'd1, 8'h00, "R8 write zero clears");
    // R5 T=1 parity error delivered
    regWrite(2'd0, 8'h07);
    sendChar(8'h5A, 1);
    regCheck(2'd1, 8'h05, "R5 status");
    regCheck(2'd2, 8'h5A, "R5 data");
    regWrite(2'd1, 8'h00);
    // R6 overrun
    sendChar(8'h11, 0);
    sendChar(8'h22, 0);
    regCheck(2'd1, 8'h03, "R6 status");
    regCheck(2'd2, 8'h11, "R6 data kept");
    regWrite(2'd1, 8'h00);
    regCheck(2'd1, 8'h00, "R8 overrun cleared");
    // R9 error-only gating
    regWrite(2'd0, 8'h0F);
    sendChar(8'h77, 0);
    chk("R9 gated by error-only", {7'b0, rxIrq}, 8'h00);
    regWrite(2'd0, 8'h07);
    chk("R9 raised", {7'b0, rxIrq}, 8'h01);
    regCheck(2'd2, 8'h77, "R1 data 77");
    // R2 glitch rejection
    @(negedge clk); cardLine = 1'b0;
    repeat (3) @(negedge clk); cardLine = 1'b1;
    idleEtus(12);
    regCheck(2'd1, 8'h00, "R2 glitch ignored");
    sendChar(8'hC3, 0);
    regCheck(2'd1, 8'h01, "R2 next frame status");
    regCheck(2'd2, 8'hC3, "R2 next frame data");
    // R11 waiting time
    idleEtus(45);
    regCheck(2'd1, 8'h08, "R11 wait error");
    chk("R10 errIrq on wait", {7'b0, errIrq}, 8'h01);
    regWrite(2'd1, 8'h00);
    idleEtus(45);
    regCheck(2'd1, 8'h00, "R11 fires once");
    // R12 disabled receiver
    regWrite(2'd0, 8'h04);
    sendChar(8'h99, 0);
    regCheck(2'd1, 8'h00, "R12 status");
    regCheck(2'd2, 8'hC3, "R12 data");
    idleEtus(45);
    regCheck(2'd1, 8'h00, "R12 no wait timer");
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule